// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Update Flag

This block is a 16-bit up-counting timer on a plain register bus. A programmable prescaler turns the system clock into count ticks, and the main counter advances on each tick. When the counter reaches the programmed reload value, the next tick wraps it to zero. That wrap is the overflow.

An overflow, or a software-forced reinitialisation, is an update event. An update event may set a sticky flag, depending on two gating bits in the control register. Software clears the flag by writing zero to it. The interrupt line is the flag ANDed with an enable bit.

The bus has no handshake: a write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. Register map (byte offsets): control 0x00, status 0x10, event generation 0x14, counter 0x24, prescaler ratio 0x28, reload value 0x2C. Unmapped offsets read as zero.

Top module: `upd_timer`

## Requirements
- R1: After reset, control, status, event-generation, counter and prescaler registers read 0. The reload register reads 0xFFFF, and `irq_o` and `upd_evt_o` are 0.
- R2: While control bit 0 (run) is 1, with prescaler ratio P, the counter advances once every P+1 clock cycles. While run is 0, neither the counter nor the prescaler phase moves.
- R3: A tick that finds the counter equal to the reload value sets the counter to 0 on that tick; this is an overflow.
- R4: An overflow sets status bit 0 (the flag) when control bit 1 (update block) is 0, and leaves the flag unchanged when it is 1.
- R5: Writing 1 to bit 0 of the event-generation register clears the counter and the prescaler phase. It leaves the prescaler ratio unchanged, so the next tick comes P+1 cycles later.
- R6: A forced update sets the flag only when control bit 1 and control bit 2 (overflow-only) are both 0.
- R7: The event-generation register always reads 0, and writing 0 to it changes nothing.
- R8: Writing the status register with bit 0 = 0 clears the flag, and with bit 0 = 1 leaves it as it was. Status bits 15:1 read 0.
- R9: When a flag clear write and a flag-setting event fall in the same cycle, the flag ends up set.
- R10: The counter register is 16 bits wide and can be read and written. A written value holds while run is 0.
- R11: `irq_o` is high exactly when the flag is 1 and control bit 3 (interrupt enable) is 1.
- R12: `upd_evt_o` pulses high for one cycle, in the cycle after each overflow or forced update, when control bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| upd_evt_o | output | 1 | One-cycle update event pulse |
| irq_o | output | 1 | Level interrupt: flag AND enable |

## Verification
The bench builds the block with its defaults: 16-bit data and an 8-bit address. It then programs small prescaler ratios (0 to 3) and reload values (0 to 7) at run time, so that wraps, flag setting and the prescaler phase can be observed within a few dozen cycles. Reload 0 puts an overflow on every tick, and ratio 3 leaves enough cycles to tell a cleared prescaler phase from a kept one. The same-cycle clear-versus-set race is lined up edge by edge from these small values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_EVG  = 8'h14;
  localparam logic [7:0] OFS_CNT  = 8'h24;
  localparam logic [7:0] OFS_PSC  = 8'h28;
  localparam logic [7:0] OFS_RLD  = 8'h2C;

  localparam int CB_RUN  = 0;
  localparam int CB_BLK  = 1;
  localparam int CB_OVFO = 2;
  localparam int CB_IEN  = 3;
  localparam int CTRL_W  = 4;

  typedef struct packed {
    logic ien;
    logic ovf_only;
    logic blk;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] phase_q;

  assign tick_o = run_i && !clr_i && (phase_q >= ratio_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (run_i)  phase_q <= tick_o ? '0 : phase_q + 1'b1;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(phase_q));
  p_clr_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         reinit_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = (cnt_q == reload_i);
  assign ovf_o  = tick_i && at_top && !reinit_i && !wr_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (reinit_i)  cnt_q <= '0;
    else if (wr_i)      cnt_q <= wdata_i;
    else if (tick_i)    cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !at_top && !reinit_i && !wr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_reinit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              upd_evt_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CTRL_W;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] psc_q;
  logic [DATA_W-1:0] rld_q;
  logic [DATA_W-1:0] cnt;
  logic              tick, ovf, flag, upd_evt_q;

  logic hit_ctrl, hit_stat, hit_evg, hit_cnt, hit_psc, hit_rld;
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_evg  = (bus_addr == ADDR_W'(OFS_EVG));
  assign hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
  assign hit_psc  = (bus_addr == ADDR_W'(OFS_PSC));
  assign hit_rld  = (bus_addr == ADDR_W'(OFS_RLD));

  logic force_upd, flag_set, flag_clr;
  assign force_upd = bus_we && hit_evg && bus_wdata[0];
  assign flag_set  = !ctrl_q.blk && (ovf || (force_upd && !ctrl_q.ovf_only));
  assign flag_clr  = bus_we && hit_stat && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      psc_q     <= '0;
      rld_q     <= '1;
      upd_evt_q <= 1'b0;
    end else begin
      if (bus_we && hit_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (bus_we && hit_psc)  psc_q  <= bus_wdata;
      if (bus_we && hit_rld)  rld_q  <= bus_wdata;
      upd_evt_q <= (ovf || force_upd) && !ctrl_q.blk;
    end
  end

  tmr_presc #(.W(DATA_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (ctrl_q.run),
    .clr_i   (force_upd),
    .ratio_i (psc_q),
    .tick_o  (tick)
  );

  tmr_count #(.W(DATA_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .reinit_i (force_upd),
    .wr_i     (bus_we && hit_cnt),
    .wdata_i  (bus_wdata),
    .reload_i (rld_q),
    .cnt_o    (cnt),
    .ovf_o    (ovf)
  );

  tmr_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
    else if (hit_stat) bus_rdata = {{(DATA_W-1){1'b0}}, flag};
    else if (hit_cnt)  bus_rdata = cnt;
    else if (hit_psc)  bus_rdata = psc_q;
    else if (hit_rld)  bus_rdata = rld_q;
  end

  assign upd_evt_o = upd_evt_q;
  assign irq_o     = flag && ctrl_q.ien;

  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.blk && !flag) |=> !flag);
  p_block_evt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.blk |=> !upd_evt_o);
  p_ovfonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf_only && !ovf && !flag) |=> !flag);
endmodule

// File: tb/test_upd_timer.sv
module test_upd_timer;
  localparam int CLK_PER = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [7:0]  psc;
    logic [7:0]  rld;
    logic [15:0] cyc;
    logic [15:0] cnt;
    logic        flg;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd0, 8'd5, 16'd3,  16'd3, 1'b0},
    '{8'd0, 8'd5, 16'd6,  16'd0, 1'b1},
    '{8'd2, 8'd4, 16'd10, 16'd3, 1'b0},
    '{8'd2, 8'd4, 16'd15, 16'd0, 1'b1},
    '{8'd1, 8'd0, 16'd1,  16'd0, 1'b0},
    '{8'd1, 8'd0, 16'd2,  16'd0, 1'b1},
    '{8'd3, 8'd7, 16'd30, 16'd7, 1'b0},
    '{8'd0, 8'd3, 16'd9,  16'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        upd_evt_o, irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  upd_timer i_upd_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_evt_o(upd_evt_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] psc, input logic [15:0] rld);
    wr(8'h00, 16'h0000);
    wr(8'h28, psc);
    wr(8'h2C, rld);
    wr(8'h14, 16'h0001);
    wr(8'h10, 16'h0000);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 16'h0000);
    rd(8'h10, v); chk("R1 stat", v, 16'h0000);
    rd(8'h14, v); chk("R1 evg", v, 16'h0000);
    rd(8'h24, v); chk("R1 cnt", v, 16'h0000);
    rd(8'h28, v); chk("R1 psc", v, 16'h0000);
    rd(8'h2C, v); chk("R1 rld", v, 16'hFFFF);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 evt", {15'd0, upd_evt_o}, 16'd0);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      setup({8'd0, VECS[i].psc}, {8'd0, VECS[i].rld});
      wr(8'h00, 16'h0001);
      idle(int'(VECS[i].cyc));
      rd(8'h24, v); chk("R2/R3 count", v, VECS[i].cnt);
      rd(8'h10, v); chk("R4 flag", v, {15'd0, VECS[i].flg});
    end

    // R2 run=0 freezes counter
    wr(8'h00, 16'h0000);
    rd(8'h24, v);
    idle(5);
    begin
      logic [15:0] w;
      rd(8'h24, w); chk("R2 frozen", w, v);
    end

    // R4 update block keeps flag clear on overflow
    setup(16'd0, 16'd2);
    wr(8'h00, 16'h0003);
    idle(5);
    rd(8'h24, v); chk("R4 blk cnt", v, 16'd2);
    rd(8'h10, v); chk("R4 blk flag", v, 16'd0);

    // R5 forced update clears prescaler phase, keeps ratio
    setup(16'd3, 16'd9);
    wr(8'h00, 16'h0001);
    idle(2);
    wr(8'h14, 16'h0001);
    idle(3);
    rd(8'h24, v); chk("R5 phase cleared", v, 16'd0);
    idle(1);
    rd(8'h24, v); chk("R5 ratio kept", v, 16'd1);

    // R6 / R12 overflow-only: update occurs, no flag
    setup(16'd0, 16'd9);
    wr(8'h00, 16'h0004);
    wr(8'h24, 16'd5);
    wr(8'h14, 16'h0001);
    chk("R12 evt pulse", {15'd0, upd_evt_o}, 16'd1);
    rd(8'h24, v); chk("R5 cnt reinit", v, 16'd0);
    rd(8'h10, v); chk("R6 ovf-only no flag", v, 16'd0);
    idle(1);
    chk("R12 evt one cycle", {15'd0, upd_evt_o}, 16'd0);
    wr(8'h00, 16'h0000);
    wr(8'h14, 16'h0001);
    rd(8'h10, v); chk("R6 forced sets flag", v, 16'd1);
    wr(8'h10, 16'h0000);
    wr(8'h00, 16'h0002);
    wr(8'h24, 16'd7);
    wr(8'h14, 16'h0001);
    chk("R12 blk no evt", {15'd0, upd_evt_o}, 16'd0);
    rd(8'h10, v); chk("R6 blk no flag", v, 16'd0);
    rd(8'h24, v); chk("R5 blk still reinit", v, 16'd0);

    // R10 / R7 counter rw, evg write 0 no effect
    wr(8'h00, 16'h0000);
    wr(8'h24, 16'h1234);
    rd(8'h24, v); chk("R10 cnt rw", v, 16'h1234);
    wr(8'h14, 16'h0000);
    rd(8'h24, v); chk("R7 evg 0 no effect", v, 16'h1234);
    rd(8'h14, v); chk("R7 evg reads 0", v, 16'h0000);
    wr(8'h24, 16'hBEEF);
    rd(8'h24, v); chk("R10 cnt full width", v, 16'hBEEF);

    // R8 status write rules
    wr(8'h14, 16'h0001);
    wr(8'h10, 16'hFFFF);
    rd(8'h10, v); chk("R8 write1 keeps", v, 16'h0001);
    wr(8'h10, 16'hFFFE);
    rd(8'h10, v); chk("R8 write0 clears", v, 16'h0000);

    // R11 interrupt gating
    wr(8'h14, 16'h0001);
    chk("R11 irq disabled", {15'd0, irq_o}, 16'd0);
    wr(8'h00, 16'h0008);
    chk("R11 irq enabled", {15'd0, irq_o}, 16'd1);
    wr(8'h10, 16'h0000);
    chk("R11 irq after clear", {15'd0, irq_o}, 16'd0);

    // R9 set wins over same-cycle clear
    setup(16'd0, 16'd3);
    wr(8'h00, 16'h0001);
    idle(3);
    wr(8'h10, 16'h0000);
    rd(8'h10, v); chk("R9 set wins", v, 16'd1);
    rd(8'h24, v); chk("R3 wrapped", v, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule